// File: doc/BRIEF.md
# ARINC Receive Word Filter with Label Memory and FIFO Status

This block sits between the word decoder of one ARINC 429 receive channel and that channel's receive FIFO. Each time the decoder presents a complete 32-bit word, the block decides whether the word is stored or dropped. Two checks can each be switched on independently. The first compares the word's label against a 16-entry label memory. The second compares the two SDI bits against a configured pair. A word is stored only when every check that is switched on passes.

The host uses a label-access mode to fill the label memory one entry per load strobe and to read it back one entry per read strobe. Outside that mode, the read strobe takes words from the FIFO in arrival order. The block drives ready, half-full and full flags. It also drives the active-low copy of each flag.

Top module: `arinc_word_filter`

## Requirements
- R1: After a synchronous active-low reset, the FIFO is empty, flag_ready, flag_half and flag_full are 0, host_data is 0, every label entry is 0x00, and both label pointers are at entry 0.
- R2: While lbl_access is 1, each cycle with host_load high writes host_label into the entry at the write pointer and advances that pointer. The pointer visits entries 0 to 15 in turn, so the 17th load overwrites entry 0. While lbl_access is 0, host_load has no effect and both label pointers return to 0.
- R3: While lbl_access is 1, host_data shows {24'h0, label at the read pointer}, and each host_read advances the read pointer by one, wrapping after entry 15.
- R4: With lbl_match_en at 1, a word is stored only if its label, word_data[7:0] (ARINC bits 1 to 8), equals one of the 16 stored entries. All entries are compared in the same cycle.
- R5: With sdi_check_en at 1, a word is stored only if word_data[8] (ARINC bit 9) equals sdi_ref[0] and word_data[9] (ARINC bit 10) equals sdi_ref[1].
- R6: A word is stored only when every enabled check passes. With both checks off, every presented word is stored. A failing word leaves the FIFO unchanged. The label lookup uses the memory contents as they stand before any load in the same cycle.
- R7: Outside label-access mode, host_data shows the oldest stored word, or 0 when the FIFO is empty. host_read removes that word. A read of an empty FIFO has no effect. Words leave in the order they arrived.
- R8: flag_ready is 1 when at least one word is stored. flag_half is 1 at 16 or more words. flag_full is 1 at 32 words. Each flag_*_n output is the inverse of its flag.
- R9: A word that passes the checks while the FIFO holds 32 words is discarded and the stored words are unchanged. This also applies when a read occurs in the same cycle, which leaves 31 words.
- R10: While lbl_access is 1, host_read does not remove a word from the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | One-cycle strobe: word_data holds a decoded word |
| word_data | input | 32 | Decoded word; [7:0] is the label, [9:8] is the SDI field |
| lbl_match_en | input | 1 | Enable label recognition |
| sdi_check_en | input | 1 | Enable SDI comparison |
| sdi_ref | input | 2 | SDI compare bits; [0] is for ARINC bit 9, [1] is for ARINC bit 10 |
| lbl_access | input | 1 | Label memory access mode |
| host_load | input | 1 | Label load strobe |
| host_label | input | 8 | Label value to load |
| host_read | input | 1 | Read strobe (FIFO pop, or label read in access mode) |
| host_data | output | 32 | Read data: FIFO head or zero-extended label |
| flag_ready | output | 1 | FIFO holds at least one word |
| flag_half | output | 1 | FIFO holds 16 or more words |
| flag_full | output | 1 | FIFO holds 32 words |
| flag_ready_n | output | 1 | Inverse of flag_ready |
| flag_half_n | output | 1 | Inverse of flag_half |
| flag_full_n | output | 1 | Inverse of flag_full |

## Verification
The assertions check on every cycle the following properties:
- The label write pointer wraps from entry 15 to entry 0.
- A word that fails an enabled label or SDI check leaves the fill level unchanged.
- A full FIFO refuses a new word, and a push together with a pop at full leaves 31 words.
- A pop from an empty FIFO has no effect.
- When both checks are off, a word is accepted.

Other behaviours only the bench scenarios can show:
- The full order of the stored words and the exact values read back.
- Label readback after the write pointer wraps.
- That reads in access mode leave the FIFO untouched.
- The flag thresholds at exactly 16 and 32 words.

// File: rtl/awf_pkg.sv
// Package: shared widths and field positions for the ARINC word filter.
// Assumes the label occupies word bits [7:0] and the SDI field bits [9:8].
package awf_pkg;
    localparam int WORD_W   = 32;
    localparam int LABEL_W  = 8;
    localparam int LABEL_LO = 0;
    localparam int SDI_LO   = 8;

    typedef logic [LABEL_W-1:0] label_t;
    typedef logic [1:0]         sdi_t;

    // Extract the label field of a decoded word
    function automatic label_t word_label(input logic [WORD_W-1:0] w);
        return w[LABEL_LO +: LABEL_W];
    endfunction

    // Extract the SDI field of a decoded word
    function automatic sdi_t word_sdi(input logic [WORD_W-1:0] w);
        return w[SDI_LO +: 2];
    endfunction
endpackage

// File: rtl/awf_label_mem.sv
// Label memory: N entries, sequential load and readback while in access
// mode, and a parallel compare of a probe label against every entry.
// Assumes: pointers are held at entry 0 whenever access mode is off.
module awf_label_mem #(
    parameter int N  = 16,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_mode,
    input  logic          wr_en,
    input  logic [LW-1:0] wr_label,
    input  logic          rd_adv,
    input  logic [LW-1:0] probe,
    output logic          hit,
    output logic [LW-1:0] rd_label
);
    localparam int AW = (N > 1) ? $clog2(N) : 1;
    localparam logic [AW-1:0] LAST = AW'(N - 1);

    logic [LW-1:0] mem [N];
    logic [AW-1:0] wptr, rptr;
    logic [N-1:0]  match;

    // Entry storage: cleared on reset, written at the write pointer in access mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) mem[i] <= '0;
        end else if (acc_mode && wr_en) begin
            mem[wptr] <= wr_label;
        end
    end

    // Pointers: advance with wrap in access mode, parked at 0 otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || !acc_mode) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (wr_en) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (rd_adv) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
        end
    end

    // One comparator per entry
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = (mem[g] == probe);
    end

    assign hit      = |match;
    assign rd_label = mem[rptr];

    // R2: write pointer wraps to entry 0 after the last entry
    a_r2_wptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_mode && wr_en && wptr == LAST) |=> (wptr == '0));
endmodule

// File: rtl/awf_accept.sv
// Acceptance decision: combines the enabled label and SDI checks.
// Assumes hit reflects the label memory before any same-cycle load.
module awf_accept (
    input  logic                         word_valid,
    input  logic [awf_pkg::WORD_W-1:0]   word_data,
    input  logic                         lbl_en,
    input  logic                         lbl_hit,
    input  logic                         sdi_en,
    input  awf_pkg::sdi_t                sdi_ref,
    output logic                         take
);
    logic lbl_ok, sdi_ok;

    // Each check passes when disabled or when it matches
    always_comb begin
        lbl_ok = !lbl_en || lbl_hit;
        sdi_ok = !sdi_en || (awf_pkg::word_sdi(word_data) == sdi_ref);
        take   = word_valid && lbl_ok && sdi_ok;
    end
endmodule

// File: rtl/awf_fifo.sv
// Receive FIFO: DEPTH words, show-ahead output (0 when empty), level-based
// ready/half/full flags. A push while full is dropped even if a pop happens.
module awf_fifo #(
    parameter int DEPTH = 32,
    parameter int W     = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         rdy,
    output logic                         half,
    output logic                         full
);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVW  = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;
    localparam logic [PW-1:0]  PLAST = PW'(DEPTH - 1);
    localparam logic [LVW-1:0] LFULL = LVW'(DEPTH);
    localparam logic [LVW-1:0] LHALF = LVW'(HALF);

    logic [W-1:0]   mem [DEPTH];
    logic [PW-1:0]  wptr, rptr;
    logic           push_ok, pop_ok;

    always_comb begin
        push_ok = push && (level != LFULL);
        pop_ok  = pop && (level != '0);
    end

    // Storage write for accepted words
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= din;
    end

    // Pointer and level bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) wptr <= (wptr == PLAST) ? '0 : wptr + 1'b1;
            if (pop_ok)  rptr <= (rptr == PLAST) ? '0 : rptr + 1'b1;
            level <= level + LVW'(push_ok) - LVW'(pop_ok);
        end
    end

    assign dout = (level != '0) ? mem[rptr] : '0;
    assign rdy  = (level != '0);
    assign half = (level >= LHALF);
    assign full = (level == LFULL);

    // R9: a full FIFO without a pop stays full
    a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> (level == LFULL));
    // R9: push and pop together at full leave DEPTH-1 words
    a_r9_full_push_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (full && pop && push) |=> (level == LFULL - 1'b1));
    // R7: popping an empty FIFO without a push leaves it empty
    a_r7_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        ((level == '0) && !push) |=> (level == '0));
    // R8: level never exceeds the depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LFULL);
endmodule

// File: rtl/arinc_word_filter.sv
// ARINC word filter top: label memory, acceptance logic and receive FIFO
// for one channel. Assumes word_valid is a one-cycle strobe per word and
// that host strobes are synchronous single-cycle pulses.
module arinc_word_filter #(
    parameter int LABELS = 16,
    parameter int DEPTH  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_valid,
    input  logic [31:0] word_data,
    input  logic        lbl_match_en,
    input  logic        sdi_check_en,
    input  logic [1:0]  sdi_ref,
    input  logic        lbl_access,
    input  logic        host_load,
    input  logic [7:0]  host_label,
    input  logic        host_read,
    output logic [31:0] host_data,
    output logic        flag_ready,
    output logic        flag_half,
    output logic        flag_full,
    output logic        flag_ready_n,
    output logic        flag_half_n,
    output logic        flag_full_n
);
    import awf_pkg::*;

    localparam int LVW = $clog2(DEPTH + 1);

    label_t              lbl_out;
    logic                lbl_hit;
    logic                take;
    logic                fifo_pop;
    logic [WORD_W-1:0]   fifo_dout;
    logic [LVW-1:0]      level;

    assign fifo_pop = host_read && !lbl_access;

    awf_label_mem #(.N(LABELS), .LW(LABEL_W)) u_lbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_mode (lbl_access),
        .wr_en    (host_load),
        .wr_label (host_label),
        .rd_adv   (host_read),
        .probe    (word_label(word_data)),
        .hit      (lbl_hit),
        .rd_label (lbl_out)
    );

    awf_accept u_acc (
        .word_valid (word_valid),
        .word_data  (word_data),
        .lbl_en     (lbl_match_en),
        .lbl_hit    (lbl_hit),
        .sdi_en     (sdi_check_en),
        .sdi_ref    (sdi_ref),
        .take       (take)
    );

    awf_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take),
        .din   (word_data),
        .pop   (fifo_pop),
        .dout  (fifo_dout),
        .level (level),
        .rdy   (flag_ready),
        .half  (flag_half),
        .full  (flag_full)
    );

    // Host read mux: label readback in access mode, FIFO head otherwise
    always_comb begin
        host_data = lbl_access ? {{(WORD_W-LABEL_W){1'b0}}, lbl_out} : fifo_dout;
    end

    assign flag_ready_n = ~flag_ready;
    assign flag_half_n  = ~flag_half;
    assign flag_full_n  = ~flag_full;

    // R4: a label miss with recognition on never changes the fill level
    a_r4_label_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && lbl_match_en && !lbl_hit && !fifo_pop) |=> $stable(level));
    // R5: an SDI mismatch with the check on never changes the fill level
    a_r5_sdi_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && sdi_check_en && (word_data[9:8] != sdi_ref) && !fifo_pop)
        |=> $stable(level));
    // R6: with both checks off and room left, a word is stored
    a_r6_accept_all: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !lbl_match_en && !sdi_check_en && !flag_full && !fifo_pop)
        |=> (level == $past(level) + 1'b1));
    // R10: reads in access mode leave the fill level alone when no word arrives
    a_r10_access_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (lbl_access && host_read && !word_valid) |=> $stable(level));
endmodule

// File: tb/sim_arinc_word_filter.sv
// Bench for arinc_word_filter: directed corner cases plus seeded random
// traffic, checked every cycle against a queue-based reference model.
module sim_arinc_word_filter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        word_valid;
    logic [31:0] word_data;
    logic        lbl_match_en, sdi_check_en;
    logic [1:0]  sdi_ref;
    logic        lbl_access, host_load, host_read;
    logic [7:0]  host_label;
    logic [31:0] host_data;
    logic        flag_ready, flag_half, flag_full;
    logic        flag_ready_n, flag_half_n, flag_full_n;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // Reference model state
    logic [7:0]  mmem [16];
    int          mwp, mrp;
    logic [31:0] q [$];

    always #10 clk = ~clk;

    arinc_word_filter u0 (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_data(word_data),
        .lbl_match_en(lbl_match_en), .sdi_check_en(sdi_check_en), .sdi_ref(sdi_ref),
        .lbl_access(lbl_access), .host_load(host_load), .host_label(host_label),
        .host_read(host_read), .host_data(host_data),
        .flag_ready(flag_ready), .flag_half(flag_half), .flag_full(flag_full),
        .flag_ready_n(flag_ready_n), .flag_half_n(flag_half_n), .flag_full_n(flag_full_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit m_hit(input logic [7:0] l);
        for (int i = 0; i < 16; i++) if (mmem[i] == l) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit m_accept(input logic [31:0] w);
        bit lok = !lbl_match_en || m_hit(w[7:0]);
        bit sok = !sdi_check_en || (w[9:8] == sdi_ref);
        return lok && sok;
    endfunction

    // Compare every output against the model (state after the last edge)
    task automatic compare_all();
        logic [31:0] exp_d;
        int n = q.size();
        if (lbl_access) exp_d = {24'h0, mmem[mrp]};
        else            exp_d = (n != 0) ? q[0] : 32'h0;
        chk(lbl_access ? "R3 label readback" : "R7 fifo head", host_data, exp_d);
        chk("R8 ready",  {31'h0, flag_ready}, {31'h0, n != 0});
        chk("R8 half",   {31'h0, flag_half},  {31'h0, n >= 16});
        chk("R8 full",   {31'h0, flag_full},  {31'h0, n == 32});
        chk("R8 inverse", {29'h0, flag_ready_n, flag_half_n, flag_full_n},
            {29'h0, ~flag_ready, ~flag_half, ~flag_full});
    endtask

    // One clock: drive at negedge, advance model, check at next negedge
    task automatic cyc(input bit v, input logic [31:0] d, input bit rd,
                       input bit ld, input logic [7:0] lv);
        bit acc, pop;
        word_valid = v; word_data = d; host_read = rd; host_load = ld; host_label = lv;
        acc = v && m_accept(d);
        pop = rd && !lbl_access && (q.size() != 0);
        if (acc && q.size() < 32) begin
            if (pop) void'(q.pop_front());
            q.push_back(d);
        end else if (pop) begin
            void'(q.pop_front());
        end
        if (lbl_access) begin
            if (ld) begin mmem[mwp] = lv; mwp = (mwp + 1) % 16; end
            if (rd) mrp = (mrp + 1) % 16;
        end else begin
            mwp = 0; mrp = 0;
        end
        @(posedge clk);
        @(negedge clk);
        word_valid = 0; host_read = 0; host_load = 0;
        compare_all();
    endtask

    task automatic idle();
        cyc(0, 32'h0, 0, 0, 8'h0);
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd4242);
        rst_n = 0; word_valid = 0; word_data = 0; lbl_match_en = 0; sdi_check_en = 0;
        sdi_ref = 0; lbl_access = 0; host_load = 0; host_label = 0; host_read = 0;
        for (int i = 0; i < 16; i++) mmem[i] = 8'h0;
        mwp = 0; mrp = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state
        chk("R1 ready", {31'h0, flag_ready}, 32'h0);
        chk("R1 full",  {31'h0, flag_full}, 32'h0);
        chk("R1 data",  host_data, 32'h0);
        lbl_access = 1;
        for (int i = 0; i < 16; i++) begin
            chk("R1 label zero", host_data, 32'h0);
            cyc(0, 0, 1, 0, 0);
        end

        // R2: 17 loads wrap onto entry 0; then read back from entry 0
        lbl_access = 0; idle(); lbl_access = 1; idle();
        for (int i = 0; i < 16; i++) cyc(0, 0, 0, 1, 8'h10 + 8'(i));
        cyc(0, 0, 0, 1, 8'hA5);
        lbl_access = 0; idle(); lbl_access = 1; idle();
        chk("R2 wrap entry0", host_data, 32'h0000_00A5);
        cyc(0, 0, 1, 0, 0);
        chk("R3 entry1", host_data, 32'h0000_0011);
        // R2: host_load outside access mode ignored
        lbl_access = 0; idle();
        cyc(0, 0, 0, 1, 8'h77);
        lbl_access = 1; idle();
        chk("R2 load ignored outside mode", host_data, 32'h0000_00A5);
        lbl_access = 0; idle();

        // R4: label recognition
        lbl_match_en = 1;
        cyc(1, 32'h1234_5610, 0, 0, 0);
        chk("R4 miss rejected", {31'h0, flag_ready}, 32'h0);
        cyc(1, 32'h1234_5611, 0, 0, 0);
        chk("R4 hit accepted", host_data, 32'h1234_5611);
        cyc(1, 32'hCAFE_00A5, 1, 0, 0);
        chk("R4 hit entry0", host_data, 32'hCAFE_00A5);
        cyc(0, 0, 1, 0, 0);
        chk("R7 drained", {31'h0, flag_ready}, 32'h0);

        // R5: SDI check only
        lbl_match_en = 0; sdi_check_en = 1; sdi_ref = 2'b10;
        cyc(1, 32'h0000_0155, 0, 0, 0);
        chk("R5 mismatch rejected", {31'h0, flag_ready}, 32'h0);
        cyc(1, 32'h0000_0255, 0, 0, 0);
        chk("R5 match accepted", host_data, 32'h0000_0255);
        cyc(0, 0, 1, 0, 0);

        // R6: both checks on
        lbl_match_en = 1; sdi_ref = 2'b01;
        cyc(1, 32'h0000_0211, 0, 0, 0);
        cyc(1, 32'h0000_0199, 0, 0, 0);
        chk("R6 one check fails", {31'h0, flag_ready}, 32'h0);
        cyc(1, 32'h0000_0112, 0, 0, 0);
        chk("R6 both pass", host_data, 32'h0000_0112);
        cyc(0, 0, 1, 0, 0);
        lbl_match_en = 0; sdi_check_en = 0;

        // R8 / R9: fill to full, overflow discard, push+pop at full
        for (int i = 0; i < 32; i++) begin
            cyc(1, 32'hF000_0000 + 32'(i), 0, 0, 0);
            if (i == 14) chk("R8 not half at 15", {31'h0, flag_half}, 32'h0);
            if (i == 15) chk("R8 half at 16", {31'h0, flag_half}, 32'h1);
            if (i == 30) chk("R8 not full at 31", {31'h0, flag_full}, 32'h0);
        end
        chk("R8 full at 32", {31'h0, flag_full}, 32'h1);
        cyc(1, 32'hDEAD_BEEF, 0, 0, 0);
        chk("R9 head unchanged", host_data, 32'hF000_0000);
        cyc(1, 32'hDEAD_BEEF, 1, 0, 0);
        chk("R9 push+pop at full", {31'h0, flag_full}, 32'h0);

        // R10: reads in access mode keep the FIFO
        lbl_access = 1; idle();
        cyc(0, 0, 1, 0, 0); cyc(0, 0, 1, 0, 0);
        lbl_access = 0; idle();
        chk("R10 fifo kept", host_data, 32'hF000_0001);
        for (int i = 0; i < 40; i++) cyc(0, 0, 1, 0, 0);
        chk("R7 empty read", host_data, 32'h0);

        // Random traffic
        for (int blk = 0; blk < 60; blk++) begin
            lbl_match_en = 1'($urandom);
            sdi_check_en = 1'($urandom);
            sdi_ref      = 2'($urandom);
            lbl_access   = ($urandom % 6) == 0;
            for (int k = 0; k < 50; k++) begin
                logic [31:0] w = $urandom;
                int rdp = (blk % 3 == 0) ? 2 : 5;
                if ($urandom % 2) w[7:0] = mmem[$urandom % 16];
                cyc(($urandom % 3) != 0, w, ($urandom % rdp) == 0,
                    ($urandom % 4) == 0, 8'($urandom));
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule